// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Float Converter

This block turns a signed fixed-point number into a 32-bit binary32 floating-point word. The operand comes in as sign-magnitude: one sign bit and a 32-bit magnitude. The upper 16 bits of the magnitude are the integer part and the lower 16 bits are the fraction. The block counts the zeros above the leading one of the magnitude. It shifts the magnitude left until that one reaches the top, then takes the exponent from the shift distance and the exponent bias. Finally it packs the sign, the biased exponent and the significand into one word. The significand is the part of the normalized value that lies below the implied leading one.

A producer offers an operand with `in_valid_i`, and the block takes it on a clock edge where `in_ready_o` is high. On the next cycle the converted word sits in an output register, `out_valid_o` rises and `done_o` pulses once. The word stays put until a consumer drives `out_ready_i`. The block takes no new operand while a result is waiting. Significand bits that fall below the kept width are dropped, which is truncation toward zero.

Top module: `fix2flt_conv`

## Requirements
- R1: The output word holds the sign in bit 31, the biased exponent in bits 30..23 and the significand in bits 22..0.
- R2: Bit 31 is 1 when `in_sign_i` is 1 and the magnitude is nonzero. In every other case it is 0.
- R3: For a nonzero magnitude whose highest set bit has index p (0 = least significant bit, 16 = units bit), the exponent field equals 127 + p − 16. The field therefore lies in 111..142.
- R4: The leading one is not stored. Bits 22..0 hold the magnitude bits below index p, left-aligned, with bit p−1 in bit 22.
- R5: Magnitude bits more than 23 places below the leading one are discarded without rounding, for example 256 + 2^-16 converts to 0x43800000.
- R6: A zero magnitude produces the all-zero word 0x00000000, whatever the sign input.
- R7: An operand is taken on a rising edge where `in_valid_i` and `in_ready_o` are both 1. Its converted word appears on `out_word_o`, with `out_valid_o` = 1 and `done_o` = 1, in the cycle that follows that edge.
- R8: `done_o` is high for exactly one cycle per accepted operand and only while `out_valid_o` is high.
- R9: While `out_valid_o` is 1, `in_ready_o` is 0, operands offered on `in_valid_i` are ignored and `out_word_o` is held. A rising edge with `out_ready_i` = 1 clears `out_valid_o`.
- R10: During and right after reset, `in_ready_o` = 1, `out_valid_o` = 0, `done_o` = 0 and `out_word_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand offered |
| in_ready_o | output | 1 | Block can take an operand |
| in_sign_i | input | 1 | Operand sign, 1 = negative |
| in_mag_i | input | 32 | Operand magnitude, 16 integer and 16 fraction bits |
| out_ready_i | input | 1 | Consumer takes the pending result |
| out_valid_o | output | 1 | Result pending |
| done_o | output | 1 | One-cycle pulse when a result is written |
| out_word_o | output | 32 | Single-precision result word |

## Verification
The hardest case to reach is truncation with nonzero discarded bits. It needs a magnitude whose leading one lies at bit 24 or above and which also has set bits more than 23 places lower, and random 32-bit words rarely give both at once. The stimulus draws random words shifted right by a random distance, so every leading-one position from 0 to 31 is visited. Directed operands then cover the extremes, the negative zero and a value whose only low bit is truncated. While a result is held, the bench also offers conflicting operands, to show they neither change the word nor raise a second pulse.

// File: rtl/fix2flt_pkg.sv
package fix2flt_pkg;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 16;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int MAG_W  = INT_W + FRAC_W;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] man;
  } flt_word_t;
endpackage

// File: rtl/lead_one_finder.sv
module lead_one_finder #(
  parameter int W    = 32,
  parameter int LZ_W = $clog2(W)
) (
  input  logic [W-1:0]    vec_i,
  output logic [LZ_W-1:0] lz_o,
  output logic            any_o
);
  // higher set bits overwrite lower ones, so the top one wins
  always_comb begin
    lz_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) lz_o = LZ_W'(W - 1 - i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/norm_shifter.sv
module norm_shifter #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    data_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    assign stage[s+1] = sh_i[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign data_o = stage[SH_W];
endmodule

// File: rtl/field_packer.sv
module field_packer
  import fix2flt_pkg::*;
#(
  parameter int P_MAG_W  = MAG_W,
  parameter int P_FRAC_W = FRAC_W,
  parameter int P_EXP_W  = EXP_W,
  parameter int P_MAN_W  = MAN_W,
  parameter int LZ_W     = $clog2(P_MAG_W),
  parameter int P_WORD_W = 1 + P_EXP_W + P_MAN_W
) (
  input  logic                sign_i,
  input  logic                any_i,
  input  logic [LZ_W-1:0]     lz_i,
  input  logic [P_MAG_W-1:0]  norm_i,
  output logic [P_WORD_W-1:0] word_o
);
  localparam int P_BIAS  = (1 << (P_EXP_W - 1)) - 1;
  // exponent when the leading one already sits at the top bit
  localparam int EXP_TOP = P_BIAS + P_MAG_W - 1 - P_FRAC_W;

  logic [P_EXP_W-1:0] expo;
  logic [P_MAN_W-1:0] man;

  assign expo = any_i ? P_EXP_W'(EXP_TOP - int'(lz_i)) : '0;

  // the cast drops the hidden bit; the shift drops the truncated tail
  if (P_MAG_W - 1 >= P_MAN_W) begin : g_trunc
    assign man = P_MAN_W'(norm_i >> (P_MAG_W - 1 - P_MAN_W));
  end else begin : g_pad
    assign man = P_MAN_W'(P_MAN_W'(norm_i) << (P_MAN_W - P_MAG_W + 1));
  end

  assign word_o = {sign_i & any_i, expo, man};
endmodule

// File: rtl/fix2flt_conv.sv
module fix2flt_conv
  import fix2flt_pkg::*;
#(
  parameter int P_INT_W  = INT_W,
  parameter int P_FRAC_W = FRAC_W,
  parameter int P_EXP_W  = EXP_W,
  parameter int P_MAN_W  = MAN_W,
  localparam int L_MAG_W  = P_INT_W + P_FRAC_W,
  localparam int L_WORD_W = 1 + P_EXP_W + P_MAN_W,
  localparam int L_LZ_W   = $clog2(L_MAG_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic                in_sign_i,
  input  logic [L_MAG_W-1:0]  in_mag_i,
  input  logic                out_ready_i,
  output logic                out_valid_o,
  output logic                done_o,
  output logic [L_WORD_W-1:0] out_word_o
);
  logic [L_LZ_W-1:0]   lz;
  logic                any;
  logic [L_MAG_W-1:0]  norm;
  logic [L_WORD_W-1:0] word_d;
  logic [L_WORD_W-1:0] word_q;
  logic                valid_q;
  logic                done_q;
  logic                accept;

  lead_one_finder #(.W(L_MAG_W), .LZ_W(L_LZ_W)) u_lof (
    .vec_i (in_mag_i),
    .lz_o  (lz),
    .any_o (any)
  );

  norm_shifter #(.W(L_MAG_W), .SH_W(L_LZ_W)) u_shift (
    .data_i (in_mag_i),
    .sh_i   (lz),
    .data_o (norm)
  );

  field_packer #(
    .P_MAG_W  (L_MAG_W),
    .P_FRAC_W (P_FRAC_W),
    .P_EXP_W  (P_EXP_W),
    .P_MAN_W  (P_MAN_W),
    .LZ_W     (L_LZ_W),
    .P_WORD_W (L_WORD_W)
  ) u_pack (
    .sign_i (in_sign_i),
    .any_i  (any),
    .lz_i   (lz),
    .norm_i (norm),
    .word_o (word_d)
  );

  assign in_ready_o = ~valid_q;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (accept) begin
      word_q  <= word_d;
      valid_q <= 1'b1;
      done_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (out_ready_i) valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign done_o      = done_q;
  assign out_word_o  = word_q;
endmodule

// File: rtl/fix2flt_conv_chk.sv
module fix2flt_conv_chk #(
  parameter int P_INT_W  = 16,
  parameter int P_FRAC_W = 16,
  parameter int P_EXP_W  = 8,
  parameter int P_MAN_W  = 23,
  localparam int L_MAG_W  = P_INT_W + P_FRAC_W,
  localparam int L_WORD_W = 1 + P_EXP_W + P_MAN_W,
  localparam int L_BIAS   = (1 << (P_EXP_W - 1)) - 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic                in_sign_i,
  input logic [L_MAG_W-1:0]  in_mag_i,
  input logic                out_ready_i,
  input logic                out_valid_o,
  input logic                done_o,
  input logic [L_WORD_W-1:0] out_word_o
);
  logic               acc;
  logic [P_EXP_W-1:0] ef;

  assign acc = in_valid_i && in_ready_o;
  assign ef  = out_word_o[L_WORD_W-2 -: P_EXP_W];

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (out_valid_o && done_o));

  assert_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> out_valid_o);

  assert_ready_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_word_o)));

  assert_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_mag_i == '0) |=> (out_word_o == '0));

  assert_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (out_word_o[L_WORD_W-1] == ($past(in_sign_i) && ($past(in_mag_i) != '0))));

  assert_exp_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ef != '0) |->
      (int'(ef) >= L_BIAS - P_FRAC_W && int'(ef) <= L_BIAS + P_INT_W - 1));
endmodule

bind fix2flt_conv fix2flt_conv_chk #(
  .P_INT_W  (P_INT_W),
  .P_FRAC_W (P_FRAC_W),
  .P_EXP_W  (P_EXP_W),
  .P_MAN_W  (P_MAN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_sign_i   (in_sign_i),
  .in_mag_i    (in_mag_i),
  .out_ready_i (out_ready_i),
  .out_valid_o (out_valid_o),
  .done_o      (done_o),
  .out_word_o  (out_word_o)
);

// File: tb/fix2flt_conv_test.sv
`timescale 1ns/1ps
module fix2flt_conv_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic [31:0] in_mag = '0;
  logic        out_ready = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic        done;
  logic [31:0] out_word;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  fix2flt_conv uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_sign_i   (in_sign),
    .in_mag_i    (in_mag),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .done_o      (done),
    .out_word_o  (out_word)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_conv(input logic s, input logic [31:0] m);
    int          p;
    logic [31:0] sh;
    p = -1;
    for (int i = 0; i < 32; i++) if (m[i]) p = i;
    if (p < 0) return 32'h0;
    sh = m << (31 - p);
    return {s, 8'(p + 111), sh[30:8]};
  endfunction

  task automatic run_one(input logic s, input logic [31:0] m, input int hold, input logic [31:0] exp_w);
    @(negedge clk);
    check(in_ready == 1'b1, "R9 ready when idle", {31'b0, in_ready}, 32'h1);
    in_valid = 1'b1; in_sign = s; in_mag = m;
    @(negedge clk);
    in_valid = 1'b0;
    check(done && out_valid, "R7 result one cycle after accept", {30'b0, done, out_valid}, 32'h3);
    check(out_word == exp_w, "R1 R2 R3 R4 R5 R6 word", out_word, exp_w);
    check(in_ready == 1'b0, "R9 ready low while pending", {31'b0, in_ready}, 32'h0);
    for (int k = 0; k < hold; k++) begin
      in_valid = 1'b1; in_sign = ~s; in_mag = ~m;
      @(negedge clk);
      in_valid = 1'b0;
      check(done == 1'b0, "R8 done is a single pulse", {31'b0, done}, 32'h0);
      check(out_valid && out_word == exp_w, "R9 held, stray operand ignored", out_word, exp_w);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && !done, "R9 result consumed", {30'b0, done, out_valid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic        s;
    logic [31:0] m;
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    check(in_ready && !out_valid && !done && out_word == 0, "R10 state in reset",
          {in_ready, out_valid, done, 29'b0} | out_word, 32'h8000_0000);
    rst_ni = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid && !done && out_word == 0, "R10 state after reset",
          {in_ready, out_valid, done, 29'b0} | out_word, 32'h8000_0000);

    run_one(1'b1, 32'h001C_C000, 2, 32'hC1E6_0000); // R1 R2 R3 -28.75
    run_one(1'b1, 32'h0005_0000, 0, 32'hC0A0_0000); // R3 -5.0
    run_one(1'b0, 32'h0001_0000, 1, 32'h3F80_0000); // R4 1.0
    run_one(1'b0, 32'h0000_8000, 0, 32'h3F00_0000); // R3 0.5
    run_one(1'b1, 32'h0000_0000, 1, 32'h0000_0000); // R6 negative zero
    run_one(1'b0, 32'h0000_0000, 0, 32'h0000_0000); // R6
    run_one(1'b0, 32'hFFFF_FFFF, 0, 32'h477F_FFFF); // R5 largest
    run_one(1'b0, 32'h0000_0001, 0, 32'h3780_0000); // R3 smallest
    run_one(1'b0, 32'h0100_0001, 1, 32'h4380_0000); // R5 tail dropped
    run_one(1'b1, 32'h7FFF_FFFF, 0, 32'hC6FF_FFFF); // R5

    for (int n = 0; n < 300; n++) begin
      s = 1'($urandom % 2);
      m = $urandom >> ($urandom % 32);
      run_one(s, m, int'($urandom % 3), ref_conv(s, m));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule